// File: doc/BRIEF.md
# Banked data memory address unit

This block resolves the 12-bit data-memory address for every operand access of a small 8-bit accumulator core. On each access the core presents the 8-bit operand field of the instruction, an access-select bit, and an indirect-select bit with a pointer index. The block resolves the address in one of three ways:

- **Access bank (access-select set):** a fixed split of the operand field. Low operands fall into bank 0. High operands land in the special-function-register area at the top of the space.
- **Banked direct (access-select clear):** a 4-bit bank register is placed above the operand field, which acts as an offset inside a 256-byte bank.
- **Indirect (indirect-select set):** one of two 12-bit pointer registers supplies the whole address.

The address path is purely combinational, so the address is valid in the same cycle as the request. The block also raises a flag whenever the resolved address lies in the special-function-register area.

The bank register and the two pointers are loaded by the core through a byte-wide write port:

- Each pointer is written as a low byte and a high byte, in separate cycles.
- A pointer can step forward by one after an indirect access, wrapping modulo 4096.
- All register updates become visible on the cycle after the write.

Top module: `dmem_addr_unit`

## Requirements
- R1: With `acc_sel`=1 and `ind_sel`=0, an operand 0x00..0x7F yields `addr_out` equal to the operand with bits 11:8 zero, whatever the bank register holds.
- R2: With `acc_sel`=1 and `ind_sel`=0, an operand 0x80..0xFF yields `addr_out` = 0xF00 | operand, i.e. 0xF80..0xFFF.
- R3: With `acc_sel`=0 and `ind_sel`=0, `addr_out` = {bank, operand}. A write with `wr_sel`=0 loads the bank from `wr_data[3:0]`, visible the next cycle. For example, bank 1 maps operands 0x00..0xFF to 0x100..0x1FF.
- R4: With `ind_sel`=1, `addr_out` equals the pointer chosen by `ptr_idx`, regardless of `acc_sel` and `op_field`.
- R5: A write with `wr_sel`=1 loads bits 7:0 of the pointer chosen by `wr_ptr` from `wr_data`. A write with `wr_sel`=2 loads bits 11:8 of that pointer from `wr_data[3:0]`. In both cases the other bits are kept, and the new value is visible the next cycle.
- R6: An indirect access with `post_inc`=1 makes the chosen pointer equal its old value plus 1, modulo 4096, on the next cycle. The other pointer is unchanged. A write to the same pointer in the same cycle takes precedence, and no increment happens.
- R7: `sfr_hit` is 1 exactly when `addr_out` is 0xF80 or above.
- R8: Reset (`rst_n`=0) clears the bank register and both pointers to zero.
- R9: A write with `wr_sel`=3 changes neither the bank register nor any pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_field | input | 8 | Operand field of the instruction |
| acc_sel | input | 1 | 1: access bank, 0: banked direct |
| ind_sel | input | 1 | 1: address from a pointer |
| ptr_idx | input | 1 | Pointer used for indirect access |
| post_inc | input | 1 | Step the used pointer after an indirect access |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 bank, 1 pointer low byte, 2 pointer high byte, 3 none |
| wr_ptr | input | 1 | Pointer targeted by a byte write |
| wr_data | input | 8 | Write data |
| addr_out | output | 12 | Resolved data address |
| sfr_hit | output | 1 | Address lies in special-function-register space |

## Verification
Access-bank operands are applied at 0x00, 0x7F, 0x80 and 0xFF, with the bank register both zero and non-zero. This separates the bank-free low half from the remapped high half, and shows that the bank value leaks into neither.

Banked accesses with bank 0x1, 0xA and 0xF place the operand beside the bank bits. Bank 0xF with operands 0x7F and 0x80 pins the exact edge of the special-function flag.

Pointers are loaded byte by byte, and a high-byte write carries extra upper data bits that must be dropped. Pointers then step across the 0xFFF wrap, are stepped back to back, and see a write and a step in the same cycle, which shows which one wins. The reserved write code is followed by reads of every register through the address output.

// File: rtl/dmau_pkg.sv
package dmau_pkg;
   typedef enum logic [1:0] {
      WR_BANK   = 2'd0,
      WR_PTR_LO = 2'd1,
      WR_PTR_HI = 2'd2,
      WR_NONE   = 2'd3
   } wr_sel_e;
endpackage

// File: rtl/dmau_bank_reg.sv
module dmau_bank_reg #(
   parameter int BSR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [BSR_W-1:0] din,
   output logic [BSR_W-1:0] bank_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bank_q <= '0;
      else if (we) bank_q <= din;
   end
endmodule

// File: rtl/dmau_ptr_reg.sv
module dmau_ptr_reg #(
   parameter int ADDR_W     = 12,
   parameter int LO_W       = 8,
   parameter bit POSTINC_EN = 1'b1,
   localparam int HI_W      = ADDR_W - LO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic              inc,
   input  logic [LO_W-1:0]   lo_din,
   input  logic [HI_W-1:0]   hi_din,
   output logic [ADDR_W-1:0] ptr_q
);
   logic [ADDR_W-1:0] ptr_nx;

   generate
      if (POSTINC_EN) begin : g_inc
         always_comb begin
            ptr_nx = ptr_q;
            if (we_lo)      ptr_nx[LO_W-1:0]      = lo_din;
            else if (we_hi) ptr_nx[ADDR_W-1:LO_W] = hi_din;
            else if (inc)   ptr_nx                = ptr_q + 1'b1;
         end
      end else begin : g_noinc
         logic unused_inc;
         assign unused_inc = inc;
         always_comb begin
            ptr_nx = ptr_q;
            if (we_lo)      ptr_nx[LO_W-1:0]      = lo_din;
            else if (we_hi) ptr_nx[ADDR_W-1:LO_W] = hi_din;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_nx;
   end
endmodule

// File: rtl/dmau_addr_sel.sv
module dmau_addr_sel #(
   parameter int               ADDR_W    = 12,
   parameter int               OFS_W     = 8,
   parameter int               NUM_PTR   = 2,
   parameter int               ACC_SPLIT = 128,
   parameter logic [ADDR_W-1:0] SFR_BASE = 12'hF80,
   localparam int BSR_W     = ADDR_W - OFS_W,
   localparam int PTR_IDX_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
   input  logic [OFS_W-1:0]          op_field,
   input  logic                      acc_sel,
   input  logic                      ind_sel,
   input  logic [PTR_IDX_W-1:0]      ptr_idx,
   input  logic [BSR_W-1:0]          bank_q,
   input  logic [NUM_PTR*ADDR_W-1:0] ptr_flat,
   output logic [ADDR_W-1:0]         addr_out,
   output logic                      sfr_hit
);
   logic [ADDR_W-1:0] ptr_sel;
   logic [ADDR_W-1:0] acc_addr;
   logic              op_high;

   always_comb begin
      ptr_sel = '0;
      for (int i = 0; i < NUM_PTR; i++) begin
         if (PTR_IDX_W'(i) == ptr_idx) ptr_sel = ptr_flat[i*ADDR_W +: ADDR_W];
      end
   end

   generate
      if (ACC_SPLIT >= (1 << OFS_W)) begin : g_acc_low_only
         assign op_high = 1'b0;
      end else begin : g_acc_split
         assign op_high = (op_field >= OFS_W'(ACC_SPLIT));
      end
   endgenerate

   assign acc_addr = op_high ? {{BSR_W{1'b1}}, op_field} : {{BSR_W{1'b0}}, op_field};

   always_comb begin
      if (ind_sel)      addr_out = ptr_sel;
      else if (acc_sel) addr_out = acc_addr;
      else              addr_out = {bank_q, op_field};
   end

   assign sfr_hit = (addr_out >= SFR_BASE);
endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit #(
   parameter int               ADDR_W     = 12,
   parameter int               OFS_W      = 8,
   parameter int               NUM_PTR    = 2,
   parameter int               ACC_SPLIT  = 128,
   parameter logic [ADDR_W-1:0] SFR_BASE  = 12'hF80,
   parameter bit               POSTINC_EN = 1'b1,
   localparam int BSR_W     = ADDR_W - OFS_W,
   localparam int HI_W      = ADDR_W - 8,
   localparam int PTR_IDX_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OFS_W-1:0]     op_field,
   input  logic                 acc_sel,
   input  logic                 ind_sel,
   input  logic [PTR_IDX_W-1:0] ptr_idx,
   input  logic                 post_inc,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [PTR_IDX_W-1:0] wr_ptr,
   input  logic [7:0]           wr_data,
   output logic [ADDR_W-1:0]    addr_out,
   output logic                 sfr_hit
);
   import dmau_pkg::*;

   generate
      if (ADDR_W <= 8 || ADDR_W > 16) begin : g_bad_addr_w
         $error("dmem_addr_unit: ADDR_W must be 9..16");
      end
      if (OFS_W < 1 || OFS_W >= ADDR_W || BSR_W > 8) begin : g_bad_ofs_w
         $error("dmem_addr_unit: OFS_W must leave 1..8 bank bits");
      end
      if (NUM_PTR < 1 || NUM_PTR > 16) begin : g_bad_nptr
         $error("dmem_addr_unit: NUM_PTR must be 1..16");
      end
      if (ACC_SPLIT < 0 || ACC_SPLIT > (1 << OFS_W)) begin : g_bad_split
         $error("dmem_addr_unit: ACC_SPLIT out of operand range");
      end
   endgenerate

   wr_sel_e                   wsel;
   logic                      bank_we;
   logic [BSR_W-1:0]          bank_q;
   logic [NUM_PTR*ADDR_W-1:0] ptr_flat;

   assign wsel    = wr_sel_e'(wr_sel);
   assign bank_we = wr_en && (wsel == WR_BANK);

   dmau_bank_reg #(.BSR_W(BSR_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bank_we),
      .din    (wr_data[BSR_W-1:0]),
      .bank_q (bank_q)
   );

   generate
      for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
         logic hit_w;
         logic hit_r;
         assign hit_w = (wr_ptr  == PTR_IDX_W'(g));
         assign hit_r = (ptr_idx == PTR_IDX_W'(g));

         dmau_ptr_reg #(
            .ADDR_W     (ADDR_W),
            .LO_W       (8),
            .POSTINC_EN (POSTINC_EN)
         ) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_lo  (wr_en && (wsel == WR_PTR_LO) && hit_w),
            .we_hi  (wr_en && (wsel == WR_PTR_HI) && hit_w),
            .inc    (ind_sel && post_inc && hit_r),
            .lo_din (wr_data),
            .hi_din (wr_data[HI_W-1:0]),
            .ptr_q  (ptr_flat[g*ADDR_W +: ADDR_W])
         );
      end
   endgenerate

   dmau_addr_sel #(
      .ADDR_W    (ADDR_W),
      .OFS_W     (OFS_W),
      .NUM_PTR   (NUM_PTR),
      .ACC_SPLIT (ACC_SPLIT),
      .SFR_BASE  (SFR_BASE)
   ) u_sel (
      .op_field (op_field),
      .acc_sel  (acc_sel),
      .ind_sel  (ind_sel),
      .ptr_idx  (ptr_idx),
      .bank_q   (bank_q),
      .ptr_flat (ptr_flat),
      .addr_out (addr_out),
      .sfr_hit  (sfr_hit)
   );
endmodule

// File: rtl/dmau_checker.sv
module dmau_checker #(
   parameter int               ADDR_W     = 12,
   parameter int               OFS_W      = 8,
   parameter int               NUM_PTR    = 2,
   parameter int               ACC_SPLIT  = 128,
   parameter logic [ADDR_W-1:0] SFR_BASE  = 12'hF80,
   parameter bit               POSTINC_EN = 1'b1,
   localparam int BSR_W     = ADDR_W - OFS_W,
   localparam int PTR_IDX_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [OFS_W-1:0]          op_field,
   input logic                      acc_sel,
   input logic                      ind_sel,
   input logic [PTR_IDX_W-1:0]      ptr_idx,
   input logic                      post_inc,
   input logic                      wr_en,
   input logic [1:0]                wr_sel,
   input logic [PTR_IDX_W-1:0]      wr_ptr,
   input logic [7:0]                wr_data,
   input logic [ADDR_W-1:0]         addr_out,
   input logic                      sfr_hit,
   input logic [BSR_W-1:0]          bank_q,
   input logic [NUM_PTR*ADDR_W-1:0] ptr_flat
);
   logic [ADDR_W-1:0]    cur_sel;
   logic [ADDR_W-1:0]    at_prev_idx;
   logic [ADDR_W-1:0]    prev_sel;
   logic [PTR_IDX_W-1:0] prev_idx;
   logic                 prev_inc;
   logic                 prev_rst;
   logic                 seen_clk;
   logic                 inc_now;

   always_comb begin
      cur_sel     = '0;
      at_prev_idx = '0;
      for (int i = 0; i < NUM_PTR; i++) begin
         if (PTR_IDX_W'(i) == ptr_idx)  cur_sel     = ptr_flat[i*ADDR_W +: ADDR_W];
         if (PTR_IDX_W'(i) == prev_idx) at_prev_idx = ptr_flat[i*ADDR_W +: ADDR_W];
      end
   end

   assign inc_now = POSTINC_EN && ind_sel && post_inc &&
                    !(wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2) && wr_ptr == ptr_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_inc <= 1'b0;
         prev_sel <= '0;
         prev_idx <= '0;
      end else begin
         prev_inc <= inc_now;
         prev_sel <= cur_sel;
         prev_idx <= ptr_idx;
      end
   end

   always_ff @(posedge clk) begin
      seen_clk <= 1'b1;
      prev_rst <= !rst_n;
      if (seen_clk === 1'b1 && prev_rst && !rst_n) begin
         a_reset_clear_r8: assert (bank_q == '0 && ptr_flat == '0)
            else $error("R8: registers not cleared in reset");
      end
   end

   p_access_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel && !ind_sel && op_field < OFS_W'(ACC_SPLIT)) |-> addr_out == ADDR_W'(op_field));

   p_access_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel && !ind_sel && op_field >= OFS_W'(ACC_SPLIT)) |->
      (addr_out[ADDR_W-1:OFS_W] == {BSR_W{1'b1}} && addr_out[OFS_W-1:0] == op_field));

   p_banked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_sel && !ind_sel) |-> addr_out == {bank_q, op_field});

   p_bank_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> bank_q == $past(wr_data[BSR_W-1:0]));

   p_indirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ind_sel |-> addr_out == cur_sel);

   p_postinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prev_inc |-> at_prev_idx == prev_sel + 1'b1);

   p_sfr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_hit |-> addr_out >= SFR_BASE);

   p_sfr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sfr_hit |-> addr_out < SFR_BASE);

   p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && !(ind_sel && post_inc)) |=>
      ($stable(bank_q) && $stable(ptr_flat)));
endmodule

bind dmem_addr_unit dmau_checker #(
   .ADDR_W     (ADDR_W),
   .OFS_W      (OFS_W),
   .NUM_PTR    (NUM_PTR),
   .ACC_SPLIT  (ACC_SPLIT),
   .SFR_BASE   (SFR_BASE),
   .POSTINC_EN (POSTINC_EN)
) u_dmau_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_field (op_field),
   .acc_sel  (acc_sel),
   .ind_sel  (ind_sel),
   .ptr_idx  (ptr_idx),
   .post_inc (post_inc),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_ptr   (wr_ptr),
   .wr_data  (wr_data),
   .addr_out (addr_out),
   .sfr_hit  (sfr_hit),
   .bank_q   (bank_q),
   .ptr_flat (ptr_flat)
);

// File: tb/dmem_addr_unit_bench.sv
module dmem_addr_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  op_field = '0;
   logic        acc_sel = 1'b0;
   logic        ind_sel = 1'b0;
   logic        ptr_idx = 1'b0;
   logic        post_inc = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd3;
   logic        wr_ptr = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [11:0] addr_out;
   logic        sfr_hit;

   typedef struct {
      logic [11:0] addr;
      logic        sfr;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   logic [3:0]  m_bank = '0;
   logic [11:0] m_ptr [2];

   always #2 clk = ~clk;

   dmem_addr_unit u_dmem_addr_unit (
      .clk(clk), .rst_n(rst_n), .op_field(op_field), .acc_sel(acc_sel),
      .ind_sel(ind_sel), .ptr_idx(ptr_idx), .post_inc(post_inc),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_ptr(wr_ptr), .wr_data(wr_data),
      .addr_out(addr_out), .sfr_hit(sfr_hit)
   );

   // Driver: apply one request, predict the address, then update the model.
   task automatic step(input logic [7:0] op, input logic acc, input logic ind,
                       input logic idx, input logic inc, input logic we,
                       input logic [1:0] ws, input logic wp, input logic [7:0] wd,
                       input string tag);
      exp_t e;
      logic [11:0] a;
      @(posedge clk);
      #1;
      op_field = op; acc_sel = acc; ind_sel = ind; ptr_idx = idx; post_inc = inc;
      wr_en = we; wr_sel = ws; wr_ptr = wp; wr_data = wd;
      if (ind)              a = m_ptr[idx];
      else if (acc)         a = (op < 8'h80) ? {4'h0, op} : {4'hF, op};
      else                  a = {m_bank, op};
      e.addr = a;
      e.sfr  = (a >= 12'hF80);
      e.tag  = tag;
      sb_q.push_back(e);
      if (we && ws == 2'd0) m_bank = wd[3:0];
      if (we && ws == 2'd1)      m_ptr[wp][7:0]  = wd;
      else if (we && ws == 2'd2) m_ptr[wp][11:8] = wd[3:0];
      if (ind && inc && !(we && (ws == 2'd1 || ws == 2'd2) && wp == idx))
         m_ptr[idx] = m_ptr[idx] + 12'd1;
   endtask

   task automatic wr(input logic [1:0] ws, input logic wp, input logic [7:0] wd,
                     input string tag);
      step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, ws, wp, wd, tag);
   endtask

   // Monitor: compare at the falling edge, mid-cycle.
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (addr_out !== e.addr || sfr_hit !== e.sfr) begin
            failures++;
            $display("FAIL %s: addr=%h sfr=%b expected addr=%h sfr=%b",
                     e.tag, addr_out, sfr_hit, e.addr, e.sfr);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      m_ptr[0] = '0;
      m_ptr[1] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R8: reset state seen through the address output
      step(8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R8 bank zero");
      step(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R8 ptr0 zero");
      step(8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R8 ptr1 zero");

      // R1 / R2 access bank split with bank 0
      step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R1 op 00");
      step(8'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R1 op 7F");
      step(8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R2 op 80");
      step(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R2 op FF");

      // R3 banked direct
      wr(2'd0, 1'b0, 8'hF1, "R3 load bank 1");
      step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R3 bank1 op 00");
      step(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R3 bank1 op FF");
      wr(2'd0, 1'b0, 8'h0A, "R3 load bank A");
      step(8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R3 bankA op 80");
      step(8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R1 bank ignored");
      step(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R2 bank ignored");
      wr(2'd0, 1'b0, 8'h0F, "R3 load bank F");
      step(8'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R7 F7F not sfr");
      step(8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R7 F80 sfr");

      // R5 byte loads of the pointers
      wr(2'd1, 1'b0, 8'h34, "R5 ptr0 low");
      wr(2'd2, 1'b0, 8'hA2, "R5 ptr0 high");
      wr(2'd1, 1'b1, 8'hFF, "R5 ptr1 low");
      wr(2'd2, 1'b1, 8'h0F, "R5 ptr1 high");
      step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R5 ptr0 234");
      step(8'h55, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R4 ptr1 FFF");

      // R6 post-increment
      step(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 8'h00, "R6 ptr1 inc");
      step(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R6 ptr1 wrap 000");
      step(8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 8'h00, "R6 ptr0 inc a");
      step(8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 8'h00, "R6 ptr0 inc b");
      step(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R6 ptr0 236");
      step(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R6 ptr1 untouched");
      step(8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 8'h90, "R6 write vs inc");
      step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R6 write wins");

      // R9 reserved write code
      wr(2'd3, 1'b0, 8'h5A, "R9 reserved ptr0");
      wr(2'd3, 1'b1, 8'hC7, "R9 reserved ptr1");
      step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R9 ptr0 kept");
      step(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R9 ptr1 kept");
      step(8'h21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R9 bank kept");

      // R8 reset again after non-zero contents
      @(posedge clk);
      #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      m_bank   = '0;
      m_ptr[0] = '0;
      m_ptr[1] = '0;
      step(8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R8 bank cleared");
      step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R8 ptr0 cleared");
      step(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 8'h00, "R8 ptr1 cleared");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule